// File: doc/BRIEF.md
# Keypad Wake and Interrupt Unit

This unit watches eight general-purpose input lines that carry the rows or columns of a key matrix. For each line, software picks which level counts as active. While a synchronised line sits at its active level, a sticky flag for that line is set. The flags are masked by a per-line enable and then by one global enable that comes from outside, and the result is merged into a single interrupt request. Lines left disabled can be used for other purposes without disturbing the request. Any matrix width from one to eight lines is therefore supported.

A second output, the wake signal, is built only from gates. It combines the raw pin levels with the polarity and enable registers, so it still works when the clock is stopped in power-down. In idle mode, when the clock runs, the synchronised flag path raises the interrupt as usual.

Software reaches three byte-wide registers over a small bus with a 2-bit address, a write strobe and combinational read data. Each register is accessed in a single cycle.

Top module: `kbd_wake_ctrl`

## Requirements
- R1: While reset is asserted, and after reset is released, the polarity, enable and flag registers all read 0, and the interrupt request is low.
- R2: For each line, polarity bit 0 makes a low level active and polarity bit 1 makes a high level active.
- R3: A level change on a line reaches its flag on the third rising clock edge after the change, through two synchroniser stages. No flag is set during the first two clock edges after reset is released.
- R4: A flag stays set after its line leaves the active level, until software clears it.
- R5: Writing a flag bit as 0 clears it, and writing it as 1 leaves it unchanged. A line that is still active sets its flag again at the same edge, so setting wins over clearing.
- R6: The interrupt request is high exactly when the global enable input is 1 and at least one flag is set whose enable bit is 1.
- R7: A flag on a line whose enable bit is 0 has no effect on the interrupt request.
- R8: The wake output is high exactly when some enabled line is at its active level on the raw pin. It needs no clock.
- R9: Address 0 is the polarity register, address 1 the enable register and address 2 the flag register. Address 3 reads 0 and ignores writes. Read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| kbd_pin | input | 8 | Raw keyboard lines |
| kbd_glob_en | input | 1 | Global keyboard interrupt enable |
| kbd_irq | output | 1 | Merged interrupt request |
| kbd_wake | output | 1 | Clockless wake-up request |

## Verification
The embedded assertions check, on every cycle, the following:
- a flag never drops without a write to the flag register;
- an active synchronised line always leaves its flag set, even when a clearing write lands at the same edge;
- the polarity register holds unless it is written;
- the synchroniser stays qualified once it is filled;
- the request never rises while the global enable is off;
- wake stays low with every line disabled.

Some behaviour only the bench scenarios can show:
- the exact three-edge latency from pin to flag;
- the polarity choice per line;
- writes to the spare address being ignored;
- the wake output following the pins while the clock is stopped.

// File: rtl/kbd_wake_pkg.sv
package kbd_wake_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  typedef logic [REG_ADDR_W-1:0] reg_addr_t;
  localparam reg_addr_t ADDR_POL   = 2'd0;
  localparam reg_addr_t ADDR_MASK  = 2'd1;
  localparam reg_addr_t ADDR_FLAG  = 2'd2;
  localparam reg_addr_t ADDR_SPARE = 2'd3;
endpackage

// File: rtl/kbd_pin_sync.sv
module kbd_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o,
  output logic             sync_vld_o
);
  localparam int unsigned CNT_W = $clog2(STAGES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(STAGES);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [CNT_W-1:0] fill_q;

  // Chain of flops per line; the first stage takes the raw pin.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  // Counts edges since reset, so that reset values in the chain are
  // never taken for pin levels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fill_q <= '0;
    else if (fill_q != FULL) fill_q <= fill_q + 1'b1;
  end

  assign sync_o     = stage_q[STAGES-1];
  assign sync_vld_o = (fill_q == FULL);

  assert_sync_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_vld_o |=> sync_vld_o);
endmodule

// File: rtl/kbd_flag_regs.sv
module kbd_flag_regs
  import kbd_wake_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_addr_t        addr_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] sync_i,
  input  logic             sync_vld_i,
  output logic [WIDTH-1:0] pol_o,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] pol_q, mask_q, flag_q;
  logic [WIDTH-1:0] hit, keep;
  logic wr_pol, wr_mask, wr_flag;

  assign wr_pol  = wr_i && (addr_i == ADDR_POL);
  assign wr_mask = wr_i && (addr_i == ADDR_MASK);
  assign wr_flag = wr_i && (addr_i == ADDR_FLAG);

  // A line is active when its synchronised level equals its polarity bit.
  assign hit  = sync_vld_i ? ~(sync_i ^ pol_q) : '0;
  assign keep = wr_flag ? (flag_q & wdata_i) : flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr_pol)  pol_q  <= wdata_i;
      if (wr_mask) mask_q <= wdata_i;
      flag_q <= keep | hit;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_POL:  rdata_o = pol_q;
      ADDR_MASK: rdata_o = mask_q;
      ADDR_FLAG: rdata_o = flag_q;
      default:   rdata_o = '0;
    endcase
  end

  assign pol_o  = pol_q;
  assign mask_o = mask_q;
  assign flag_o = flag_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (pol_q == '0 && mask_q == '0 && flag_q == '0));
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  assert_flag_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((flag_q & $past(hit)) == $past(hit)));
  assert_pol_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pol |=> $stable(pol_q));
endmodule

// File: rtl/kbd_req_merge.sv
module kbd_req_merge #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] flag_i,
  input  logic             glob_en_i,
  output logic             irq_o,
  output logic             wake_o
);
  logic [WIDTH-1:0] raw_hit;

  // Clockless path: raw pin against polarity, gated by the per-line enable.
  assign raw_hit = ~(pin_raw_i ^ pol_i) & mask_i;
  assign wake_o  = |raw_hit;
  assign irq_o   = glob_en_i & (|(flag_i & mask_i));

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> glob_en_i);
  assert_wake_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |-> !wake_o);
endmodule

// File: rtl/kbd_wake_ctrl.sv
module kbd_wake_ctrl
  import kbd_wake_pkg::*;
#(
  parameter int unsigned NUM_KEYS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr,
  input  logic [NUM_KEYS-1:0]   reg_wdata,
  output logic [NUM_KEYS-1:0]   reg_rdata,
  input  logic [NUM_KEYS-1:0]   kbd_pin,
  input  logic                  kbd_glob_en,
  output logic                  kbd_irq,
  output logic                  kbd_wake
);
  logic [NUM_KEYS-1:0] sync_lvl, pol, mask, flag;
  logic                sync_vld;

  kbd_pin_sync #(.WIDTH(NUM_KEYS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(kbd_pin),
    .sync_o(sync_lvl), .sync_vld_o(sync_vld)
  );

  kbd_flag_regs #(.WIDTH(NUM_KEYS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .wr_i(reg_wr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata),
    .sync_i(sync_lvl), .sync_vld_i(sync_vld),
    .pol_o(pol), .mask_o(mask), .flag_o(flag)
  );

  kbd_req_merge #(.WIDTH(NUM_KEYS)) u_merge (
    .clk(clk), .rst_n(rst_n), .pin_raw_i(kbd_pin), .pol_i(pol),
    .mask_i(mask), .flag_i(flag), .glob_en_i(kbd_glob_en),
    .irq_o(kbd_irq), .wake_o(kbd_wake)
  );
endmodule

// File: tb/kbd_wake_ctrl_bench.sv
`timescale 1ns/1ps
module kbd_wake_ctrl_bench;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] kbd_pin = 8'hFF;
  logic       kbd_glob_en = 1'b0;
  logic       kbd_irq, kbd_wake;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  kbd_wake_ctrl u_kbd_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kbd_pin(kbd_pin),
    .kbd_glob_en(kbd_glob_en), .kbd_irq(kbd_irq), .kbd_wake(kbd_wake)
  );

  initial forever begin
    #5;
    if (clk_run) clk = ~clk;
  end

  // Behavioural reference: a two-entry queue of pin samples plus registers.
  logic [7:0] m_q[$];
  logic [7:0] m_pol = 0, m_en = 0, m_flag = 0;
  int m_fill = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q = {}; m_pol = 0; m_en = 0; m_flag = 0; m_fill = 0;
    end else begin
      logic [7:0] act;
      act = (m_fill >= 2) ? ~(m_q[0] ^ m_pol) : 8'h00;
      if (reg_wr && reg_addr == 2'd2) m_flag = m_flag & reg_wdata;
      m_flag = m_flag | act;
      if (reg_wr && reg_addr == 2'd0) m_pol = reg_wdata;
      if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata;
      m_q.push_back(kbd_pin);
      if (m_q.size() > 2) void'(m_q.pop_front());
      if (m_fill < 2) m_fill++;
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [7:0] exp_rd;
      case (reg_addr)
        2'd0: exp_rd = m_pol;
        2'd1: exp_rd = m_en;
        2'd2: exp_rd = m_flag;
        default: exp_rd = 8'h00;
      endcase
      chk("R9 rdata", reg_rdata, exp_rd);
      chk("R6 irq", {7'd0, kbd_irq}, {7'd0, kbd_glob_en & |(m_flag & m_en)});
      chk("R8 wake", {7'd0, kbd_wake}, {7'd0, |(~(kbd_pin ^ m_pol) & m_en)});
    end
  end

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    #2;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rd_chk("R1 pol reset", 2'd0, 8'h00);
    chk("R1 irq reset", {7'd0, kbd_irq}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R1 pol", 2'd0, 8'h00);
    rd_chk("R1 en", 2'd1, 8'h00);
    rd_chk("R1 flag", 2'd2, 8'h00);

    // R3: latency of the two synchroniser stages
    @(negedge clk); kbd_pin[0] = 1'b0;
    repeat (2) @(negedge clk);
    rd_chk("R3 flag not yet", 2'd2, 8'h00);
    @(negedge clk);
    rd_chk("R3 flag set", 2'd2, 8'h01);

    // R4: sticky flag
    kbd_pin[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd_chk("R4 sticky", 2'd2, 8'h01);

    // R5: clear by writing 0, write of 1 has no effect, set wins
    @(negedge clk);
    wr_reg(2'd2, 8'hFF);
    rd_chk("R5 write one keeps", 2'd2, 8'h01);
    wr_reg(2'd2, 8'hFE);
    rd_chk("R5 clear", 2'd2, 8'h00);
    kbd_pin[2] = 1'b0;
    repeat (4) @(negedge clk);
    wr_reg(2'd2, 8'h00);
    rd_chk("R5 set wins", 2'd2, 8'h04);
    kbd_pin[2] = 1'b1;
    repeat (3) @(negedge clk);
    wr_reg(2'd2, 8'h00);
    rd_chk("R5 clear after release", 2'd2, 8'h00);

    // R2: line 3 high-active
    wr_reg(2'd0, 8'h08);
    @(negedge clk);
    rd_chk("R2 high active", 2'd2, 8'h08);
    rd_chk("R2 pol readback", 2'd0, 8'h08);
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd2, 8'h00);
    rd_chk("R2 low level inactive for high pin", 2'd2, 8'h00);

    // R6 / R7
    wr_reg(2'd1, 8'h01);
    kbd_pin[4] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R7 flag on disabled line", 2'd2, 8'h10);
    kbd_glob_en = 1'b1; #2;
    chk("R7 disabled line no irq", {7'd0, kbd_irq}, 8'h00);
    kbd_pin[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 irq raised", {7'd0, kbd_irq}, 8'h01);
    kbd_glob_en = 1'b0; #2;
    chk("R6 global gate", {7'd0, kbd_irq}, 8'h00);
    kbd_glob_en = 1'b1;
    kbd_pin = 8'hFF;
    repeat (3) @(negedge clk);
    wr_reg(2'd2, 8'h00);
    chk("R6 irq drops after clear", {7'd0, kbd_irq}, 8'h00);

    // R8: wake with the clock stopped
    wr_reg(2'd1, 8'h20);
    clk_run = 1'b0;
    #3 kbd_pin[5] = 1'b0;
    #3 chk("R8 wake no clock", {7'd0, kbd_wake}, 8'h01);
    kbd_pin[5] = 1'b1;
    #3 chk("R8 wake release", {7'd0, kbd_wake}, 8'h00);
    kbd_pin[6] = 1'b0;
    #3 chk("R8 disabled line no wake", {7'd0, kbd_wake}, 8'h00);
    kbd_pin[6] = 1'b1;
    #3 clk_run = 1'b1;
    @(negedge clk);

    // R9: spare address
    wr_reg(2'd3, 8'hFF);
    rd_chk("R9 spare reads zero", 2'd3, 8'h00);
    rd_chk("R9 enable untouched", 2'd1, 8'h20);
    rd_chk("R9 polarity untouched", 2'd0, 8'h00);

    // Mixed traffic checked by the per-cycle model comparison
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      kbd_pin     = 8'($urandom);
      kbd_glob_en = 1'($urandom);
      reg_addr    = 2'($urandom);
      reg_wdata   = 8'($urandom);
      reg_wr      = ($urandom % 4) == 0;
    end
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule